// File: doc/BRIEF.md
# PC-Card Access Sequencer with Run-Time I/O Sizing

This block sits between an internal requester and the PC-Card bus of a two-slot host. Each request carries a 32-bit address, a read/write flag and up to 16 bits of write data. The block decodes the address into a slot and an address space, then runs the card bus cycle for that space. It drives the card address pins, the attribute-select line, the slot-select line, the two byte-lane enables and the access strobes. It returns one response pulse that carries the read data or an error flag.

Common-memory and attribute accesses are always one 16-bit transfer. An I/O access starts out as a 16-bit transfer. The card can confirm that width by pulling the 16-bit acknowledge input low during a short sampling window. If the card does not, the access turns into two byte transfers on the low data lane, the first at A0 = 0 and the second at A0 = 1, with one idle clock between them. The setup, strobe, hold and sampling-window lengths are fixed parameters (defaults 2, 3, 1 and 2 clocks).

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle, so the requester must hold `req_valid` and the request fields until a clock edge where both are high. The response is a one-cycle pulse with no back-pressure. The requester has to take it in the cycle it appears.

Top module: `pccard_seq`

## Requirements
- R1: Address decode. The slot is `req_addr[28]`. The space is `req_addr[27:26]`: 0 is I/O, 1 is reserved, 2 is attribute memory, 3 is common memory. `card_addr` carries `req_addr[25:0]`. The only exception is bit 0 during the byte transfers of a split I/O access.
- R2: An address in a reserved partition, or any address whose bits [31:29] are not 3'b001, gives `rsp_valid` with `rsp_err` = 1 in the first cycle after acceptance. No strobe or card enable goes low for that access, and `rsp_rdata` is 0.
- R3: `card_addr`, `card_slot` (= slot) and `card_reg_n` (low only for attribute space) are valid from the first cycle after acceptance and through every strobe cycle of the access.
- R4: A common-memory or attribute access drives both card enables low from the first cycle. It makes exactly one transfer, on `card_oe_n` for a read or `card_we_n` for a write. The response comes SETUP+STROBE+HOLD+1 cycles after acceptance.
- R5: An I/O access uses only `card_iord_n` and `card_iowr_n`, never the memory strobes. Both card enables stay high during the first ACK_WIN cycles after acceptance.
- R6: If `card_iois16_n` is low at any clock edge that ends one of those ACK_WIN cycles, the I/O access is one transfer with both enables low. The response comes ACK_WIN+SETUP+STROBE+HOLD+1 cycles after acceptance.
- R7: Otherwise the I/O access makes two transfers with `card_ce2_n` high and `card_ce1_n` low. A0 is 0 in the first and 1 in the second. The second strobe starts STROBE+HOLD+1+SETUP cycles after the first. The response comes ACK_WIN+2*(SETUP+STROBE+HOLD)+2 cycles after acceptance.
- R8: A 16-bit read returns `card_rdata` as sampled in the last strobe cycle. A split read returns the first byte in `rsp_rdata[7:0]` and the second in `[15:8]`. A 16-bit write drives `req_wdata` on `card_wdata` with `card_wdata_oe` high. A split write drives the low byte and then the high byte on `card_wdata[7:0]`, with `[15:8]` zero. Writes return `rsp_rdata` = 0.
- R9: Each strobe stays low for exactly STROBE consecutive cycles, and at most one strobe is low at a time.
- R10: `req_ready` is low from acceptance through the response cycle. `rsp_valid` lasts exactly one cycle. A request held valid during the response cycle is accepted at the next edge, not before.
- R11: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, `card_wdata_oe` is 0, and all strobes, card enables and `card_reg_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access refused (reserved or out of range) |
| rsp_rdata | output | 16 | Read result |
| card_addr | output | 26 | Card address pins |
| card_reg_n | output | 1 | Attribute-space select, active low |
| card_slot | output | 1 | Slot select |
| card_ce1_n | output | 1 | Low-lane (D[7:0]) enable, active low |
| card_ce2_n | output | 1 | High-lane (D[15:8]) enable, active low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wdata | output | 16 | Data driven to the card |
| card_wdata_oe | output | 1 | Data drive enable |
| card_rdata | input | 16 | Data from the card |
| card_iois16_n | input | 1 | Card acknowledges a 16-bit I/O transfer, active low |

## Verification
Two events can fall in the same cycle: the completion pulse of one access and the presented request of the next. The bench raises `req_valid` for each new access in the very cycle the previous response appears. It then judges from the next access's measured latency and strobe positions that the request was taken only once the sequencer was idle. A second pair is the 16-bit acknowledge and the edge that closes its sampling window. The bench asserts the acknowledge exactly on the last window cycle, which must give a 16-bit transfer, and one cycle later, which must split. It does this for every slot, direction and A0 value, and expects the latency, lane enables and byte ordering computed from the requirements.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int CARD_AW = 26;
  localparam int DATA_W  = 16;

  typedef enum logic [1:0] {
    SP_IO   = 2'd0,
    SP_RSVD = 2'd1,
    SP_ATTR = 2'd2,
    SP_MEM  = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACKW,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP,
    ST_RESP
  } seq_state_e;

  typedef struct packed {
    logic   ok;
    logic   slot;
    space_e space;
  } decode_t;
endpackage

// File: rtl/pcc_addr_decode.sv
module pcc_addr_decode
  import pcc_pkg::*;
#(
  parameter logic [2:0] REGION_TAG = 3'b001
) (
  input  logic [31:0] addr,
  output decode_t     dec
);
  logic   in_region;
  space_e sp;

  always_comb begin
    in_region = (addr[31:29] == REGION_TAG);
    sp        = space_e'(addr[27:26]);
    dec.slot  = addr[28];
    dec.space = sp;
    dec.ok    = in_region && (sp != SP_RSVD);
  end
endmodule

// File: rtl/pcc_phase_timer.sv
module pcc_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val - CNT_W'(1);
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == '0);

  // R9: a phase is never loaded with zero length (strobe width exact)
  assert_nonzero_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0))
    else $error("phase timer loaded with zero length");
endmodule

// File: rtl/pcc_lane_unit.sv
module pcc_lane_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  logic              half,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] card_rdata,
  output logic [DATA_W-1:0] card_wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] rdata_q;
  logic [LANE_W-1:0] byte_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (clear) begin
      rdata_q <= '0;
    end else if (capture) begin
      if (wide)      rdata_q                  <= card_rdata;
      else if (half) rdata_q[DATA_W-1:LANE_W] <= card_rdata[LANE_W-1:0];
      else           rdata_q[LANE_W-1:0]      <= card_rdata[LANE_W-1:0];
    end
  end

  assign byte_sel   = half ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
  assign card_wdata = wide ? wdata : {{LANE_W{1'b0}}, byte_sel};
  assign rdata      = rdata_q;

  // R8: the second-byte capture only happens on a split access
  assert_second_byte_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && half) |-> !wide)
    else $error("upper byte captured on a 16-bit access");
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
  import pcc_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int ACK_WIN    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [15:0] rsp_rdata,
  output logic [25:0] card_addr,
  output logic        card_reg_n,
  output logic        card_slot,
  output logic        card_ce1_n,
  output logic        card_ce2_n,
  output logic        card_oe_n,
  output logic        card_we_n,
  output logic        card_iord_n,
  output logic        card_iowr_n,
  output logic [15:0] card_wdata,
  output logic        card_wdata_oe,
  input  logic [15:0] card_rdata,
  input  logic        card_iois16_n
);
  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B   = (HOLD_CYC > ACK_WIN) ? HOLD_CYC : ACK_WIN;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_e          st, nxt;
  decode_t             dec;
  logic [CARD_AW-1:0]  addr_q;
  logic                slot_q, write_q, wide_q, half_q, err_q;
  space_e              space_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                fire, phase_last, load;
  logic [CNT_W-1:0]    load_val;
  logic                io_q, active, lanes_on, strobing, capture;

  pcc_addr_decode u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  pcc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (phase_last)
  );

  assign req_ready = (st == ST_IDLE);
  assign fire      = req_valid && req_ready;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:   if (req_valid) nxt = !dec.ok ? ST_RESP :
                                      (dec.space == SP_IO) ? ST_ACKW : ST_SETUP;
      ST_ACKW:   if (phase_last) nxt = ST_SETUP;
      ST_SETUP:  if (phase_last) nxt = ST_STROBE;
      ST_STROBE: if (phase_last) nxt = ST_HOLD;
      ST_HOLD:   if (phase_last) nxt = (!wide_q && !half_q) ? ST_GAP : ST_RESP;
      ST_GAP:    nxt = ST_SETUP;
      ST_RESP:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    load = (nxt != st);
    unique case (nxt)
      ST_ACKW:   load_val = CNT_W'(ACK_WIN);
      ST_SETUP:  load_val = CNT_W'(SETUP_CYC);
      ST_STROBE: load_val = CNT_W'(STROBE_CYC);
      ST_HOLD:   load_val = CNT_W'(HOLD_CYC);
      default:   load_val = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      slot_q  <= 1'b0;
      space_q <= SP_MEM;
      write_q <= 1'b0;
      wdata_q <= '0;
      wide_q  <= 1'b1;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st <= nxt;
      if (fire) begin
        addr_q  <= req_addr[CARD_AW-1:0];
        slot_q  <= dec.slot;
        space_q <= dec.space;
        write_q <= req_write;
        wdata_q <= req_wdata;
        err_q   <= !dec.ok;
        wide_q  <= (dec.space != SP_IO);
        half_q  <= 1'b0;
      end
      if (st == ST_ACKW && !card_iois16_n) wide_q <= 1'b1;
      if (st == ST_HOLD && nxt == ST_GAP)  half_q <= 1'b1;
    end
  end

  assign io_q     = (space_q == SP_IO);
  assign active   = (st != ST_IDLE) && (st != ST_RESP);
  assign lanes_on = (st == ST_SETUP) || (st == ST_STROBE) ||
                    (st == ST_HOLD)  || (st == ST_GAP);
  assign strobing = (st == ST_STROBE);
  assign capture  = strobing && phase_last && !write_q;

  assign card_addr[CARD_AW-1:1] = addr_q[CARD_AW-1:1];
  assign card_addr[0]  = (st == ST_ACKW || wide_q) ? addr_q[0] : half_q;
  assign card_slot     = slot_q;
  assign card_reg_n    = !(active && space_q == SP_ATTR);
  assign card_ce1_n    = !lanes_on;
  assign card_ce2_n    = !(lanes_on && wide_q);
  assign card_oe_n     = !(strobing && !io_q && !write_q);
  assign card_we_n     = !(strobing && !io_q &&  write_q);
  assign card_iord_n   = !(strobing &&  io_q && !write_q);
  assign card_iowr_n   = !(strobing &&  io_q &&  write_q);
  assign card_wdata_oe = active && write_q;

  pcc_lane_unit #(.DATA_W(DATA_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (fire),
    .capture    (capture),
    .wide       (wide_q),
    .half       (half_q),
    .wdata      (wdata_q),
    .card_rdata (card_rdata),
    .card_wdata (card_wdata),
    .rdata      (rsp_rdata)
  );

  assign rsp_valid = (st == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;

  // R9: never two strobes at once
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}) <= 1)
    else $error("overlapping strobes");

  // R10: no new request is taken while a response is out
  assert_busy_on_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready)
    else $error("ready during response");

  // R10: response is a single-cycle pulse
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");

  // R2: a refused access answers right after acceptance
  assert_err_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_ready))
    else $error("error response not immediate");

  // R7: an I/O strobe with the high lane off must use the low lane
  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!card_iord_n || !card_iowr_n) && card_ce2_n) |-> !card_ce1_n)
    else $error("byte transfer without low-lane enable");

  // R3: attribute select never accompanies an I/O strobe
  assert_attr_no_io_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !card_reg_n |-> (card_iord_n && card_iowr_n))
    else $error("attribute select during I/O strobe");
endmodule

// File: tb/pccard_seq_test.sv
`timescale 1ns/1ps
module pccard_seq_test;
  localparam int S = 2, T = 3, H = 1, W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata, card_wdata, card_rdata;
  logic [25:0] card_addr;
  logic        card_reg_n, card_slot, card_ce1_n, card_ce2_n;
  logic        card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_wdata_oe;
  logic        card_iois16_n = 1'b1;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pccard_seq #(.SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H), .ACK_WIN(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .card_addr(card_addr), .card_reg_n(card_reg_n), .card_slot(card_slot),
    .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n),
    .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
    .card_wdata(card_wdata), .card_wdata_oe(card_wdata_oe),
    .card_rdata(card_rdata), .card_iois16_n(card_iois16_n)
  );

  function automatic logic [15:0] fmodel(input logic [25:0] a);
    return {a[15:8] + 8'h11, a[7:0] ^ 8'h96};
  endfunction

  assign card_rdata = fmodel(card_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic run_access(input bit wr, input logic [31:0] addr, input logic [15:0] wd, input int ack_at);
    bit inrange = (addr[31:29] == 3'b001);
    int sp = int'(addr[27:26]);
    bit ok = inrange && (sp != 1);
    bit io = (sp == 0);
    bit wide = !io || (ack_at <= W);
    int exp_lat = !ok ? 1 : (io ? (wide ? W+S+T+H+1 : W+2*(S+T+H)+2) : S+T+H+1);
    int exp_x = !ok ? 0 : (wide ? 1 : 2);
    string lat_req = !ok ? "R2" : (!io ? "R4" : (wide ? "R6" : "R7"));
    logic [15:0] lo_w, hi_w, exp_rd, exp_wd;
    int cyc = 0, xfer = 0, run = 0, st1 = -1, st2 = -1, guard = 0;
    bit prev_low = 0, any_ce = 0, sl, type_ok;
    lo_w = fmodel({addr[25:1], 1'b0});
    hi_w = fmodel({addr[25:1], 1'b1});
    if (!ok || wr)  exp_rd = 16'h0;
    else if (wide)  exp_rd = fmodel(addr[25:0]);
    else            exp_rd = {hi_w[7:0], lo_w[7:0]};

    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) begin
      @(negedge clk);
      guard++;
      if (guard > 100) break;
    end
    check(rsp_valid == 0, "R10 pulse", rsp_valid, 0);
    @(posedge clk);
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) req_valid = 0;
      sl = !card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n;
      check(!req_ready, "R10 busy", req_ready, 0);
      if (!card_ce1_n || !card_ce2_n) any_ce = 1;
      if (ok && cyc == 1) begin
        check(card_addr == addr[25:0], "R1 addr", card_addr, addr[25:0]);
        check(card_slot == addr[28], "R3 slot", card_slot, addr[28]);
        check(card_reg_n == (sp != 2), "R3 reg", card_reg_n, (sp != 2));
        if (!io) check({card_ce2_n, card_ce1_n} == 2'b00, "R4 ce", {card_ce2_n, card_ce1_n}, 0);
      end
      if (ok && io && cyc <= W)
        check({card_ce2_n, card_ce1_n} == 2'b11, "R5 ce window", {card_ce2_n, card_ce1_n}, 3);
      if (sl) begin
        if (!prev_low) begin
          xfer++;
          if (xfer == 1) st1 = cyc; else st2 = cyc;
        end
        run++;
        type_ok = io ? (wr ? !card_iowr_n : !card_iord_n) : (wr ? !card_we_n : !card_oe_n);
        check(type_ok, io ? "R5 strobe" : "R4 strobe",
              {card_iowr_n, card_iord_n, card_we_n, card_oe_n}, 0);
        check(card_addr[25:1] == addr[25:1], "R1 addr hi", card_addr[25:1], addr[25:1]);
        check(card_addr[0] == (wide ? addr[0] : (xfer == 2)), "R7 a0", card_addr[0], wide ? addr[0] : (xfer == 2));
        check(card_slot == addr[28], "R3 slot", card_slot, addr[28]);
        check(card_reg_n == (sp != 2), "R3 reg", card_reg_n, (sp != 2));
        check({card_ce2_n, card_ce1_n} == (wide ? 2'b00 : 2'b10), wide ? "R6 ce" : "R7 ce",
              {card_ce2_n, card_ce1_n}, wide ? 0 : 2);
        if (wr) begin
          exp_wd = wide ? wd : ((xfer == 1) ? {8'h00, wd[7:0]} : {8'h00, wd[15:8]});
          check(card_wdata_oe && card_wdata == exp_wd, "R8 wdata", {card_wdata_oe, card_wdata}, {1'b1, exp_wd});
        end
      end else if (prev_low) begin
        check(run == T, "R9 width", run, T);
        run = 0;
      end
      prev_low = sl;
      if (rsp_valid || cyc > 200) break;
    end
    check(cyc == exp_lat, lat_req, cyc, exp_lat);
    check(xfer == exp_x, "R7 transfers", xfer, exp_x);
    check(rsp_err == !ok, "R2 err", rsp_err, !ok);
    check(rsp_rdata == exp_rd, "R8 rdata", rsp_rdata, exp_rd);
    if (!ok) check(!any_ce, "R2 no enable", any_ce, 0);
    if (exp_x == 2) check(st2 - st1 == T+H+1+S, "R7 gap", st2 - st1, T+H+1+S);
    card_iois16_n = 1;
  endtask

  // drive the acknowledge from the cycle counter of the running access
  int ack_at_g = 99;
  int acc_cyc = 0;
  always @(negedge clk) begin
    if (!req_ready && !rsp_valid) begin
      acc_cyc <= acc_cyc + 1;
      card_iois16_n <= !(acc_cyc + 1 >= ack_at_g);
    end else begin
      acc_cyc <= 0;
      card_iois16_n <= 1'b1;
    end
  end

  initial begin
    int idx = 0;
    int acks[4] = '{1, W, W+1, 99};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(req_ready && !rsp_valid && !card_wdata_oe, "R11 ctl", {req_ready, rsp_valid, card_wdata_oe}, 3'b100);
    check({card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n, card_reg_n} == 7'h7F,
          "R11 pins", {card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n, card_reg_n}, 7'h7F);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R11 after", {req_ready, rsp_valid}, 2'b10);
    check({card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n} == 6'h3F,
          "R11 strobes", {card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n}, 6'h3F);

    for (int slot = 0; slot < 2; slot++)
      for (int sp = 0; sp < 4; sp++)
        for (int wr = 0; wr < 2; wr++)
          for (int ak = 0; ak < 4; ak++)
            for (int a0 = 0; a0 < 2; a0++) begin
              logic [31:0] ad;
              logic [25:0] off;
              off = 26'((idx * 32'h0001_3579) & 32'h03FF_FFFE) | 26'(a0);
              ad = 32'h2000_0000 | (32'(slot) << 28) | (32'(sp) << 26) | 32'(off);
              ack_at_g = acks[ak];
              run_access(wr[0], ad, 16'((idx * 16'h1357) ^ 16'hC0DE), acks[ak]);
              idx++;
            end

    // R2 out-of-range addresses
    ack_at_g = 99;
    run_access(1'b0, 32'h1FFF_FFFE, 16'h0, 99);
    run_access(1'b1, 32'h4000_0000, 16'hBEEF, 99);
    run_access(1'b0, 32'hFFFF_FFFF, 16'h0, 99);
    run_access(1'b1, 32'h0000_0000, 16'h1234, 99);

    summary();
    $finish;
  end
endmodule